// File: doc/BRIEF.md
# Segment Selector Load Checker

This block decides whether a selector may be loaded into the stack segment register or into one of the other data segment registers while the processor runs in protected mode. A request carries the 16-bit selector, the target kind (stack or other data register) and the current privilege level. The block classifies the selector and checks it against the limit of the descriptor table it names. If the selector passes, the block issues a read of the 8-byte descriptor and waits for both descriptor words to return.

It then applies the type, privilege and presence rules for the target kind. The result is a single-cycle strobe. On success the strobe comes with the selector and the two descriptor words, which form the new hidden cache entry. On failure it comes with the exception vector and the error code. A null selector bound for a non-stack register is accepted at once as an all-zero cache entry, and no descriptor read is made.

The descriptor read is a simple request/response exchange. `rd_req` stays high with a stable table choice and byte offset until `rd_valid` is seen. Only one request is in flight at a time, and `busy` tells the requester when the block can take a new one.

Top module: `seg_load_checker`

## Requirements
- R1: A selector with bits 15:2 all zero is null. A null selector for the stack target ends in a fault with vector 13 and error code 0, and no descriptor read is made.
- R2: A null selector for a non-stack target is accepted without a descriptor read. The accepted cache entry holds the selector as given, with both descriptor words zero.
- R3: For a non-null selector, the descriptor read names the local table when selector bit 2 is 1 and the global table when it is 0. The byte offset is the selector with bits 2:0 cleared. `rd_req` holds with a stable offset until `rd_valid` arrives.
- R4: When offset + 7 exceeds the limit of the chosen table, the result is vector 13 with error code selector AND 0xFFFC, and no read is made. An offset + 7 equal to the limit is in range.
- R5: A descriptor whose system/segment flag (high word bit 12) is 0 gives vector 13.
- R6: For the stack target, the descriptor must be a data segment (high bit 11 = 0) that is writable (high bit 9 = 1). Otherwise the result is vector 13.
- R7: For the stack target, both the selector RPL (bits 1:0) and the DPL (high bits 14:13) must equal the CPL. Otherwise the result is vector 13.
- R8: For a non-stack target, a code segment (bit 11 = 1) that is not readable (bit 9 = 0) gives vector 13.
- R9: For a non-stack target, a data segment or a non-conforming code segment (bit 10 = 0) gives vector 13 when DPL < CPL or DPL < RPL. A conforming code segment is exempt from this check.
- R10: A descriptor whose present bit (high bit 15) is 0 gives vector 12 for the stack target and vector 11 otherwise. The error code is selector AND 0xFFFC.
- R11: Checks run in this order: null, limit, segment flag, type and privilege, present. Only the first failure is reported.
- R12: Each request yields exactly one one-cycle strobe: `done_ok` or `done_fault`, never both. After a read, the strobe appears in the cycle after `rd_valid`. On success, the cache outputs carry the selector and both descriptor words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a check, taken when busy is low |
| req_is_ss | input | 1 | 1 = stack target, 0 = other data register |
| req_sel | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| gdt_limit | input | LIM_W | Global table limit in bytes |
| ldt_limit | input | LIM_W | Local table limit in bytes |
| busy | output | 1 | A check is in progress |
| rd_req | output | 1 | Descriptor read request |
| rd_ldt | output | 1 | Read targets the local table |
| rd_offset | output | 16 | Byte offset of the descriptor in its table |
| rd_valid | input | 1 | Descriptor words are valid |
| rd_lo | input | 32 | Low descriptor word |
| rd_hi | input | 32 | High descriptor word |
| done_ok | output | 1 | Load accepted strobe |
| done_fault | output | 1 | Load rejected strobe |
| fault_vec | output | 8 | Exception vector (11, 12 or 13) |
| fault_err | output | 16 | Error code |
| cache_sel | output | 16 | Selector for the cache entry |
| cache_lo | output | 32 | Low descriptor word for the cache entry |
| cache_hi | output | 32 | High descriptor word for the cache entry |

## Verification
The bench targets the cases where a slip turns one answer into another. A selector of 4 is not null, because the table bit is set. A design that masks too much would accept it as null instead of fetching from the local table. The limit test sits exactly on offset + 7 = limit, where an off-by-one rejects a valid entry. Conforming code with a low DPL must pass for a data register, and a wrong exemption either faults here or lets a low-DPL data segment through. A missing present bit must give vector 12 only for the stack target. When the present bit and an earlier rule fail together, a design with the checks in the wrong order would report 11 or 12 instead of 13.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int SEL_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [7:0] {
        VEC_NP = 8'd11,
        VEC_SS = 8'd12,
        VEC_GP = 8'd13
    } fault_vec_e;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       seg;
        logic       code;
        logic       conf;
        logic       rw;
    } desc_attr_t;

    typedef struct packed {
        logic             fault;
        fault_vec_e       vec;
        logic [SEL_W-1:0] err;
    } verdict_t;

    function automatic desc_attr_t attr_of(input logic [WORD_W-1:0] hi);
        desc_attr_t a;
        a.present = hi[15];
        a.dpl     = hi[14:13];
        a.seg     = hi[12];
        a.code    = hi[11];
        a.conf    = hi[10];
        a.rw      = hi[9];
        return a;
    endfunction

    function automatic logic [SEL_W-1:0] err_code(input logic [SEL_W-1:0] sel);
        return {sel[SEL_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/sel_decode.sv
module sel_decode
    import seg_chk_pkg::*;
#(
    parameter int LIM_W = 32
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [LIM_W-1:0] gdt_limit,
    input  logic [LIM_W-1:0] ldt_limit,
    output logic             is_null,
    output logic             use_ldt,
    output logic [SEL_W-1:0] offset,
    output logic [LIM_W-1:0] limit,
    output logic             over_limit
);
    localparam int CW = ((LIM_W > SEL_W) ? LIM_W : SEL_W) + 1;

    logic [CW-1:0] last_byte;

    always_comb begin
        is_null    = (sel[SEL_W-1:2] == '0);
        use_ldt    = sel[2];
        offset     = {sel[SEL_W-1:3], 3'b000};
        limit      = use_ldt ? ldt_limit : gdt_limit;
        last_byte  = CW'(offset) + CW'(7);
        over_limit = last_byte > CW'(limit);
    end
endmodule

// File: rtl/desc_rules.sv
module desc_rules
    import seg_chk_pkg::*;
(
    input  logic              is_ss,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        cpl,
    input  logic [WORD_W-1:0] hi,
    output verdict_t          verdict
);
    desc_attr_t a;
    logic [1:0] rpl;
    logic       type_bad;
    logic       priv_bad;

    always_comb begin
        a   = attr_of(hi);
        rpl = sel[1:0];
        if (is_ss) begin
            type_bad = a.code || !a.rw;
            priv_bad = (rpl != cpl) || (a.dpl != cpl);
        end else begin
            type_bad = a.code && !a.rw;
            priv_bad = (!a.code || !a.conf) && ((a.dpl < cpl) || (a.dpl < rpl));
        end

        verdict.fault = 1'b0;
        verdict.vec   = VEC_GP;
        verdict.err   = err_code(sel);
        if (!a.seg || type_bad || priv_bad) begin
            verdict.fault = 1'b1;
        end else if (!a.present) begin
            verdict.fault = 1'b1;
            verdict.vec   = is_ss ? VEC_SS : VEC_NP;
        end
    end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
    import seg_chk_pkg::*;
#(
    parameter int LIM_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_is_ss,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        cpl,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [LIM_W-1:0]  ldt_limit,
    output logic              busy,
    output logic              rd_req,
    output logic              rd_ldt,
    output logic [15:0]       rd_offset,
    input  logic              rd_valid,
    input  logic [31:0]       rd_lo,
    input  logic [31:0]       rd_hi,
    output logic              done_ok,
    output logic              done_fault,
    output logic [7:0]        fault_vec,
    output logic [15:0]       fault_err,
    output logic [15:0]       cache_sel,
    output logic [31:0]       cache_lo,
    output logic [31:0]       cache_hi
);
    localparam int CW = ((LIM_W > SEL_W) ? LIM_W : SEL_W) + 1;

    typedef enum logic {ST_IDLE, ST_FETCH} state_e;

    state_e           state_q;
    logic [SEL_W-1:0] sel_q;
    logic             ss_q;
    logic [1:0]       cpl_q;
    logic             ldt_q;
    logic [SEL_W-1:0] off_q;
    logic [LIM_W-1:0] lim_q;

    logic             dec_null;
    logic             dec_ldt;
    logic [SEL_W-1:0] dec_off;
    logic [LIM_W-1:0] dec_lim;
    logic             dec_over;
    verdict_t         rule_v;

    sel_decode #(.LIM_W(LIM_W)) u_dec (
        .sel        (req_sel),
        .gdt_limit  (gdt_limit),
        .ldt_limit  (ldt_limit),
        .is_null    (dec_null),
        .use_ldt    (dec_ldt),
        .offset     (dec_off),
        .limit      (dec_lim),
        .over_limit (dec_over)
    );

    desc_rules u_rules (
        .is_ss   (ss_q),
        .sel     (sel_q),
        .cpl     (cpl_q),
        .hi      (rd_hi),
        .verdict (rule_v)
    );

    assign busy      = (state_q == ST_FETCH);
    assign rd_req    = (state_q == ST_FETCH);
    assign rd_ldt    = ldt_q;
    assign rd_offset = off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            sel_q      <= '0;
            ss_q       <= 1'b0;
            cpl_q      <= '0;
            ldt_q      <= 1'b0;
            off_q      <= '0;
            lim_q      <= '0;
            done_ok    <= 1'b0;
            done_fault <= 1'b0;
            fault_vec  <= '0;
            fault_err  <= '0;
            cache_sel  <= '0;
            cache_lo   <= '0;
            cache_hi   <= '0;
        end else begin
            done_ok    <= 1'b0;
            done_fault <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        sel_q <= req_sel;
                        ss_q  <= req_is_ss;
                        cpl_q <= cpl;
                        ldt_q <= dec_ldt;
                        off_q <= dec_off;
                        lim_q <= dec_lim;
                        if (dec_null) begin
                            if (req_is_ss) begin
                                done_fault <= 1'b1;
                                fault_vec  <= VEC_GP;
                                fault_err  <= '0;
                            end else begin
                                done_ok   <= 1'b1;
                                cache_sel <= req_sel;
                                cache_lo  <= '0;
                                cache_hi  <= '0;
                            end
                        end else if (dec_over) begin
                            done_fault <= 1'b1;
                            fault_vec  <= VEC_GP;
                            fault_err  <= err_code(req_sel);
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (rd_valid) begin
                        state_q <= ST_IDLE;
                        if (rule_v.fault) begin
                            done_fault <= 1'b1;
                            fault_vec  <= rule_v.vec;
                            fault_err  <= rule_v.err;
                        end else begin
                            done_ok   <= 1'b1;
                            cache_sel <= sel_q;
                            cache_lo  <= rd_lo;
                            cache_hi  <= rd_hi;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    logic [CW-1:0] fetch_end;
    assign fetch_end = CW'(off_q) + CW'(7);

    assert_one_result_R12: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && done_fault));

    assert_no_null_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_ldt || (rd_offset != '0)));

    assert_fetch_in_limit_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (fetch_end <= CW'(lim_q)));

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_offset) && $stable(rd_ldt)));

    assert_result_after_read_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid) |=> (done_ok || done_fault));

    assert_err_masked_R10: assert property (@(posedge clk) disable iff (rst)
        done_fault |-> (fault_err[1:0] == 2'b00));

    assert_vec_legal_R10: assert property (@(posedge clk) disable iff (rst)
        done_fault |-> (fault_vec == 8'd11 || fault_vec == 8'd12 || fault_vec == 8'd13));
endmodule

// File: tb/seg_load_checker_tb.sv
module seg_load_checker_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_ss;
    logic [15:0] req_sel;
    logic [1:0]  cpl;
    logic [31:0] gdt_limit, ldt_limit;
    logic        busy, rd_req, rd_ldt, rd_valid;
    logic [15:0] rd_offset;
    logic [31:0] rd_lo, rd_hi;
    logic        done_ok, done_fault;
    logic [7:0]  fault_vec;
    logic [15:0] fault_err, cache_sel;
    logic [31:0] cache_lo, cache_hi;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    seg_load_checker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_ss(req_is_ss),
        .req_sel(req_sel), .cpl(cpl), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
        .busy(busy), .rd_req(rd_req), .rd_ldt(rd_ldt), .rd_offset(rd_offset),
        .rd_valid(rd_valid), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .done_ok(done_ok), .done_fault(done_fault), .fault_vec(fault_vec),
        .fault_err(fault_err), .cache_sel(cache_sel), .cache_lo(cache_lo),
        .cache_hi(cache_hi)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int p, input int dpl, input int s,
                                       input int code, input int conf, input int rw);
        return 32'h00C0_0000 | (p << 15) | (dpl << 13) | (s << 12) |
               (code << 11) | (conf << 10) | (rw << 9) | 32'h12;
    endfunction

    // Behavioural model: walks the rules in priority order.
    task automatic model(input bit ss, input int sel, input int c, input logic [31:0] hi,
                         output bit fetch, output bit ok, output int vec, output int err);
        int  off, lim, rpl, dpl;
        bit  present, s, code, conf, rw, bad;
        off = sel & 'hFFF8;
        lim = ((sel & 4) != 0) ? int'(ldt_limit) : int'(gdt_limit);
        err = sel & 'hFFFC;
        fetch = 0; ok = 0; vec = 13;
        if ((sel & 'hFFFC) == 0) begin
            if (ss) err = 0; else ok = 1;
            return;
        end
        if (off + 7 > lim) return;
        fetch = 1;
        rpl = sel & 3; dpl = (hi >> 13) & 3;
        present = hi[15]; s = hi[12]; code = hi[11]; conf = hi[10]; rw = hi[9];
        if (!s) return;
        if (ss) bad = code || !rw || rpl != c || dpl != c;
        else    bad = (code && !rw) || ((!code || !conf) && (dpl < c || dpl < rpl));
        if (bad) return;
        if (!present) begin vec = ss ? 12 : 11; return; end
        ok = 1;
    endtask

    task automatic run(input string tag, input bit ss, input logic [15:0] sel, input logic [1:0] c,
                       input logic [31:0] hi, input logic [31:0] lo, input int dly);
        bit e_fetch, e_ok, fetched, got;
        int e_vec, e_err, waited;
        model(ss, int'(sel), int'(c), hi, e_fetch, e_ok, e_vec, e_err);
        fetched = 0; got = 0; waited = 0;
        @(negedge clk);
        req_valid = 1; req_is_ss = ss; req_sel = sel; cpl = c;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (done_ok || done_fault) begin
                got = 1;
                check({tag, " R12 ok"}, {31'b0, done_ok}, {31'b0, e_ok});
                check({tag, " R12 single"}, {31'b0, done_ok & done_fault}, 0);
                check({tag, " R3 fetch"}, {31'b0, fetched}, {31'b0, e_fetch});
                if (e_ok) begin
                    check({tag, " R12 sel"}, {16'b0, cache_sel}, {16'b0, sel});
                    check({tag, " R2 lo"}, cache_lo, e_fetch ? lo : 0);
                    check({tag, " R2 hi"}, cache_hi, e_fetch ? hi : 0);
                end else begin
                    check({tag, " R10 vec"}, {24'b0, fault_vec}, e_vec);
                    check({tag, " R10 err"}, {16'b0, fault_err}, e_err);
                end
            end else if (rd_req) begin
                if (!fetched) begin
                    check({tag, " R3 ldt"}, {31'b0, rd_ldt}, {31'b0, sel[2]});
                    check({tag, " R3 off"}, {16'b0, rd_offset}, {16'b0, sel & 16'hFFF8});
                end
                fetched = 1;
                if (waited == dly) begin
                    rd_valid = 1; rd_hi = hi; rd_lo = lo;
                end else begin
                    waited++;
                end
            end
            @(negedge clk);
            rd_valid = 0; rd_hi = 32'hDEAD_BEEF; rd_lo = 32'hDEAD_BEEF;
        end
        check({tag, " R12 result seen"}, {31'b0, got}, 1);
        check({tag, " R12 pulse ends"}, {30'b0, done_ok, done_fault}, 0);
    endtask

    initial begin
        rst = 1; req_valid = 0; req_is_ss = 0; req_sel = 0; cpl = 0;
        gdt_limit = 32'h0000_00FF; ldt_limit = 32'h0000_003F;
        rd_valid = 0; rd_lo = 0; rd_hi = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("reset R12 done", {30'b0, done_ok, done_fault}, 0);
        check("reset R3 rd_req", {30'b0, rd_req, busy}, 0);

        run("null ds R2", 0, 16'h0003, 2'd3, 32'h0, 32'h0, 0);
        run("null ss R1", 1, 16'h0002, 2'd0, 32'h0, 32'h0, 0);
        run("ldt idx0 R3", 0, 16'h0004, 2'd0, mk(1,0,1,0,0,1), 32'hAAAA_0001, 1);
        run("gdt over R4", 0, 16'h0100, 2'd0, mk(1,0,1,0,0,1), 32'h1, 0);
        run("ldt over R4", 0, 16'h0044, 2'd0, mk(1,0,1,0,0,1), 32'h1, 0);
        run("gdt edge R4", 0, 16'h00F8, 2'd0, mk(1,0,1,0,0,1), 32'h5555_0000, 2);
        run("ldt edge R4", 1, 16'h003C, 2'd0, mk(1,0,1,0,0,1), 32'h7, 0);
        run("sys desc R5", 0, 16'h0010, 2'd0, mk(1,0,0,0,0,1), 32'h1, 0);
        run("ss code R6", 1, 16'h0010, 2'd0, mk(1,0,1,1,0,1), 32'h1, 0);
        run("ss ro R6", 1, 16'h0010, 2'd0, mk(1,0,1,0,0,0), 32'h1, 0);
        run("ss rpl R7", 1, 16'h0013, 2'd0, mk(1,0,1,0,0,1), 32'h1, 0);
        run("ss dpl R7", 1, 16'h0013, 2'd3, mk(1,2,1,0,0,1), 32'h1, 0);
        run("ss good R7", 1, 16'h0012, 2'd2, mk(1,2,1,0,0,1), 32'hBEEF, 3);
        run("exec only R8", 0, 16'h0018, 2'd0, mk(1,0,1,1,0,0), 32'h1, 0);
        run("read code R8", 0, 16'h0018, 2'd0, mk(1,0,1,1,0,1), 32'h2, 1);
        run("dpl<cpl R9", 0, 16'h0020, 2'd3, mk(1,1,1,0,0,1), 32'h1, 0);
        run("dpl<rpl R9", 0, 16'h0023, 2'd0, mk(1,1,1,0,0,1), 32'h1, 0);
        run("nonconf R9", 0, 16'h0020, 2'd2, mk(1,1,1,1,0,1), 32'h1, 0);
        run("conform R9", 0, 16'h0023, 2'd3, mk(1,0,1,1,1,1), 32'h3, 0);
        run("np ss R10", 1, 16'h0028, 2'd0, mk(0,0,1,0,0,1), 32'h1, 0);
        run("np ds R10", 0, 16'h002B, 2'd0, mk(0,3,1,0,0,1), 32'h1, 1);
        run("order sys+np R11", 1, 16'h0030, 2'd0, mk(0,0,0,0,0,1), 32'h1, 0);
        run("order priv+np R11", 0, 16'h0030, 2'd2, mk(0,0,1,0,0,1), 32'h1, 0);
        run("order type+np R11", 1, 16'h0030, 2'd0, mk(0,0,1,1,0,1), 32'h1, 0);

        for (int i = 0; i < 300; i++) begin
            logic [15:0] s;
            s = 16'($urandom);
            if (i % 3 == 0) s = s & 16'h00FF;
            if (i % 7 == 0) s = s & 16'h0007;
            run("random R11", 1'($urandom), s, 2'($urandom), $urandom, $urandom, int'($urandom % 4));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule